// File: doc/BRIEF.md
# Speculative Return-Slot Scheduler

This block sits on the controller side of a memory channel whose memory stacks handle their own device timing. The controller owns a shared return data bus. The bus is cut in time into slots, and each slot is exactly long enough to carry one cache line. A read leaves the block as an address, a module select and a tag, with no per-bank commands. In the same cycle the block books two future slots on the return bus: a primary slot and a backup slot. The memory module may return the line in either of them.

Each module reports its memory latency: address transfer, plus bank access, plus bus flight. Software or the memory side writes that figure into a per-module latency register, and no device timing is hard-coded. A request issued at cycle t may only land in a slot that starts at or after t plus that latency. The block keeps a circular occupancy bitmap of the next 64 slots. That bitmap moves forward one entry per slot period, so a passed slot frees its entry. When the channel reports which slot carried the data, the block releases the other booking at once, so that a later read can take it. If no primary and backup pair fits inside the bitmap horizon, the request waits with ready low.

Top module: `slot_sched`

## Requirements
- R1: After reset the bitmap is empty, the slot counter `slot_now_o` is 0, and with default latencies a request is accepted (`req_ready_o` high).
- R2: Each module has its own latency register, reset to `DEF_LAT` cycles. A write takes effect from the cycle after the write, so a request in the write cycle still uses the old value.
- R3: Slot s starts at cycle s*SLOT_CYC, counted from the first cycle after reset. For a request at cycle t with latency L, the primary slot is the lowest unbooked slot s with s*SLOT_CYC >= t+L and s greater than the current slot.
- R4: The backup slot is the lowest unbooked slot that is strictly later than the primary slot.
- R5: A slot that is booked and not released is never granted again until it has passed.
- R6: If the primary or the backup does not fit within the 63 slots after the current one, `req_ready_o` is low, and neither `mem_valid_o` nor `gnt_valid_o` is raised.
- R7: On acceptance, in the same cycle, `mem_*` carry the request's address, module and tag, and `gnt_*` carry the tag and the two slots. Slot numbers are the absolute slot count modulo 128.
- R8: A completion with `cpl_use_i`=0 (primary used) frees that tag's backup slot if the backup is still ahead. A completion with `cpl_use_i`=1 (backup used) frees nothing.
- R9: A request in the same cycle as a release is searched against the bitmap with the release already applied.
- R10: When the counter leaves a slot, that slot's bitmap entry is cleared, so the same entry can be booked again one horizon later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Latency register write strobe |
| cfg_mod_i | input | MOD_W | Module whose latency is written |
| cfg_lat_i | input | LAT_W | New latency in cycles |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | A slot pair is available for this request |
| req_addr_i | input | ADDR_W | Request address |
| req_mod_i | input | MOD_W | Target memory module |
| req_tag_i | input | TAG_W | Request tag |
| mem_valid_o | output | 1 | Address issued to memory |
| mem_addr_o | output | ADDR_W | Issued address |
| mem_mod_o | output | MOD_W | Issued module select |
| mem_tag_o | output | TAG_W | Issued tag |
| gnt_valid_o | output | 1 | Slot pair granted |
| gnt_tag_o | output | TAG_W | Tag of the grant |
| gnt_prim_o | output | IDX_W+1 | Primary slot number |
| gnt_bkup_o | output | IDX_W+1 | Backup slot number |
| cpl_valid_i | input | 1 | Completion report valid |
| cpl_tag_i | input | TAG_W | Completed tag |
| cpl_use_i | input | 1 | 0: primary used, 1: backup used |
| slot_now_o | output | IDX_W+1 | Current slot number |

## Verification
Some properties are checked on every cycle. A primary slot never starts before issue time plus latency. The backup always lies beyond the primary and inside the horizon. A granted slot was free in the post-release bitmap and is marked as booked on the next cycle. A stalled request never produces an address or a grant. Other behaviour only shows up in the bench's scenarios:

- that the chosen slots are the lowest eligible ones
- the one-cycle delay of latency writes
- the release on a primary-used completion
- the same-cycle release that turns a stall into a grant
- reuse of bitmap entries once the horizon has wrapped

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic {
    USE_PRIM = 1'b0,
    USE_BKUP = 1'b1
  } slot_use_e;
endpackage

// File: rtl/slot_lat_regs.sv
module slot_lat_regs #(
  parameter int NUM_MOD = 4,
  parameter int LAT_W   = 9,
  parameter int DEF_LAT = 40,
  localparam int MOD_W  = $clog2(NUM_MOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [MOD_W-1:0] wmod_i,
  input  logic [LAT_W-1:0] wlat_i,
  input  logic [MOD_W-1:0] rmod_i,
  output logic [LAT_W-1:0] rlat_o
);
  logic [LAT_W-1:0] lat_q [NUM_MOD];

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 lat_q[m] <= LAT_W'(DEF_LAT);
      else if (we_i && (wmod_i == MOD_W'(m)))      lat_q[m] <= wlat_i;
    end
  end

  assign rlat_o = lat_q[rmod_i];
endmodule

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_SLOTS = 64,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 adv_i,
  input  logic [IDX_W-1:0]     cur_i,
  input  logic                 rel_i,
  input  logic [IDX_W-1:0]     rel_idx_i,
  input  logic                 book_i,
  input  logic [IDX_W-1:0]     book_p_i,
  input  logic [IDX_W-1:0]     book_b_i,
  output logic [NUM_SLOTS-1:0] busy_o,
  output logic [NUM_SLOTS-1:0] tbl_o
);
  logic [NUM_SLOTS-1:0] tbl_q, rel_mask, exp_mask, book_mask;

  always_comb begin
    rel_mask  = '0;
    exp_mask  = '0;
    book_mask = '0;
    if (rel_i) rel_mask[rel_idx_i] = 1'b1;
    if (adv_i) exp_mask[cur_i] = 1'b1;
    if (book_i) begin
      book_mask[book_p_i] = 1'b1;
      book_mask[book_b_i] = 1'b1;
    end
  end

  // search view: release of this cycle already applied
  assign busy_o = tbl_q & ~rel_mask;
  assign tbl_o  = tbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tbl_q <= '0;
    else         tbl_q <= (busy_o & ~exp_mask) | book_mask;
  end
endmodule

// File: rtl/slot_finder.sv
module slot_finder #(
  parameter int NUM_SLOTS = 64,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] busy_i,
  input  logic [IDX_W-1:0]     base_i,
  input  logic [IDX_W-1:0]     min_off_i,
  output logic                 prim_ok_o,
  output logic [IDX_W-1:0]     prim_off_o,
  output logic                 bkup_ok_o,
  output logic [IDX_W-1:0]     bkup_off_o
);
  logic [NUM_SLOTS-1:0] free_rel, cand_p, cand_b;
  logic [IDX_W-1:0]     prim_off;

  // rotate the bitmap so bit k is the slot k periods ahead; offset 0 is never eligible
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_rot
    if (k == 0) begin : g_now
      assign free_rel[k] = 1'b0;
      assign cand_p[k]   = 1'b0;
    end else begin : g_fut
      assign free_rel[k] = ~busy_i[base_i + IDX_W'(k)];
      assign cand_p[k]   = free_rel[k] & (IDX_W'(k) >= min_off_i);
    end
  end

  always_comb begin
    prim_ok_o = 1'b0;
    prim_off  = '0;
    for (int k = NUM_SLOTS - 1; k >= 1; k--) begin
      if (cand_p[k]) begin
        prim_ok_o = 1'b1;
        prim_off  = IDX_W'(k);
      end
    end
  end

  always_comb begin
    cand_b = '0;
    for (int k = 1; k < NUM_SLOTS; k++) cand_b[k] = free_rel[k] && (IDX_W'(k) > prim_off);
  end

  always_comb begin
    bkup_ok_o  = 1'b0;
    bkup_off_o = '0;
    for (int k = NUM_SLOTS - 1; k >= 1; k--) begin
      if (cand_b[k]) begin
        bkup_ok_o  = prim_ok_o;
        bkup_off_o = IDX_W'(k);
      end
    end
  end

  assign prim_off_o = prim_off;
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_CYC  = 4,
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 4,
  parameter int NUM_MOD   = 4,
  parameter int LAT_W     = 9,
  parameter int DEF_LAT   = 40,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int STAMP_W  = IDX_W + 1,
  localparam int MOD_W    = $clog2(NUM_MOD)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [MOD_W-1:0]   cfg_mod_i,
  input  logic [LAT_W-1:0]   cfg_lat_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [MOD_W-1:0]   req_mod_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  output logic               mem_valid_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [MOD_W-1:0]   mem_mod_o,
  output logic [TAG_W-1:0]   mem_tag_o,
  output logic               gnt_valid_o,
  output logic [TAG_W-1:0]   gnt_tag_o,
  output logic [STAMP_W-1:0] gnt_prim_o,
  output logic [STAMP_W-1:0] gnt_bkup_o,
  input  logic               cpl_valid_i,
  input  logic [TAG_W-1:0]   cpl_tag_i,
  input  logic               cpl_use_i,
  output logic [STAMP_W-1:0] slot_now_o
);
  localparam int PH_W     = $clog2(SLOT_CYC);
  localparam int NUM_TAGS = 1 << TAG_W;
  localparam int SUM_W    = LAT_W + 2;

  // slot clock
  logic [PH_W-1:0]    phase_q;
  logic [STAMP_W-1:0] stamp_q;
  logic               adv;

  assign adv = (phase_q == PH_W'(SLOT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      stamp_q <= '0;
    end else begin
      phase_q <= adv ? '0 : phase_q + 1'b1;
      if (adv) stamp_q <= stamp_q + 1'b1;
    end
  end

  // latency of the addressed module
  logic [LAT_W-1:0] lat_sel;

  slot_lat_regs #(
    .NUM_MOD (NUM_MOD),
    .LAT_W   (LAT_W),
    .DEF_LAT (DEF_LAT)
  ) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wmod_i (cfg_mod_i),
    .wlat_i (cfg_lat_i),
    .rmod_i (req_mod_i),
    .rlat_o (lat_sel)
  );

  // earliest eligible offset: ceil((phase + lat) / SLOT_CYC), at least 1
  logic [SUM_W-1:0] reach, need_off;
  logic [IDX_W-1:0] min_off;
  logic             in_hzn;

  assign reach    = SUM_W'(phase_q) + SUM_W'(lat_sel) + SUM_W'(SLOT_CYC - 1);
  assign need_off = reach >> PH_W;
  assign in_hzn   = need_off < SUM_W'(NUM_SLOTS);
  assign min_off  = (need_off == '0) ? IDX_W'(1) : need_off[IDX_W-1:0];

  // release of the unused backup
  logic [STAMP_W-1:0]  bk_q [NUM_TAGS];
  logic [NUM_TAGS-1:0] live_q;
  logic [STAMP_W-1:0]  rel_stamp, rel_dist;
  logic [IDX_W-1:0]    rel_idx;
  logic                rel_en;

  assign rel_stamp = bk_q[cpl_tag_i];
  assign rel_dist  = rel_stamp - stamp_q;
  assign rel_idx   = rel_stamp[IDX_W-1:0];
  assign rel_en    = cpl_valid_i && live_q[cpl_tag_i]
                  && (slot_use_e'(cpl_use_i) == USE_PRIM)
                  && (rel_dist != '0) && (rel_dist < STAMP_W'(NUM_SLOTS));

  // bitmap and search
  logic [NUM_SLOTS-1:0] busy, tbl_all;
  logic                 prim_ok, bkup_ok, fire;
  logic [IDX_W-1:0]     prim_off, bkup_off;
  logic [STAMP_W-1:0]   prim_stamp, bkup_stamp;

  slot_finder #(.NUM_SLOTS(NUM_SLOTS)) u_find (
    .busy_i     (busy),
    .base_i     (stamp_q[IDX_W-1:0]),
    .min_off_i  (min_off),
    .prim_ok_o  (prim_ok),
    .prim_off_o (prim_off),
    .bkup_ok_o  (bkup_ok),
    .bkup_off_o (bkup_off)
  );

  assign req_ready_o = in_hzn & prim_ok & bkup_ok;
  assign fire        = req_valid_i & req_ready_o;
  assign prim_stamp  = stamp_q + STAMP_W'(prim_off);
  assign bkup_stamp  = stamp_q + STAMP_W'(bkup_off);

  slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .cur_i     (stamp_q[IDX_W-1:0]),
    .rel_i     (rel_en),
    .rel_idx_i (rel_idx),
    .book_i    (fire),
    .book_p_i  (prim_stamp[IDX_W-1:0]),
    .book_b_i  (bkup_stamp[IDX_W-1:0]),
    .busy_o    (busy),
    .tbl_o     (tbl_all)
  );

  // per-tag backup record; a grant on a tag wins over its completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
    end else begin
      if (cpl_valid_i) live_q[cpl_tag_i] <= 1'b0;
      if (fire)        live_q[req_tag_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fire) bk_q[req_tag_i] <= bkup_stamp;
  end

  assign mem_valid_o = fire;
  assign mem_addr_o  = req_addr_i;
  assign mem_mod_o   = req_mod_i;
  assign mem_tag_o   = req_tag_i;
  assign gnt_valid_o = fire;
  assign gnt_tag_o   = req_tag_i;
  assign gnt_prim_o  = prim_stamp;
  assign gnt_bkup_o  = bkup_stamp;
  assign slot_now_o  = stamp_q;
endmodule

// File: rtl/slot_sched_chk.sv
module slot_sched_chk #(
  parameter int NUM_SLOTS = 64,
  parameter int SLOT_CYC  = 4,
  parameter int LAT_W     = 9,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int STAMP_W  = IDX_W + 1,
  localparam int PH_W     = $clog2(SLOT_CYC)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic                 req_ready_o,
  input logic                 mem_valid_o,
  input logic                 gnt_valid_o,
  input logic [STAMP_W-1:0]   gnt_prim_o,
  input logic [STAMP_W-1:0]   gnt_bkup_o,
  input logic [STAMP_W-1:0]   slot_now_o,
  input logic [PH_W-1:0]      phase_q,
  input logic [LAT_W-1:0]     lat_sel,
  input logic [NUM_SLOTS-1:0] tbl_q,
  input logic                 rel_valid,
  input logic [IDX_W-1:0]     rel_idx
);
  logic [STAMP_W-1:0] dp, db;
  logic [IDX_W-1:0]   pidx, bidx;
  int                 lead_p, need_p;

  assign dp     = gnt_prim_o - slot_now_o;
  assign db     = gnt_bkup_o - slot_now_o;
  assign pidx   = gnt_prim_o[IDX_W-1:0];
  assign bidx   = gnt_bkup_o[IDX_W-1:0];
  assign lead_p = int'(dp) * SLOT_CYC;
  assign need_p = int'(phase_q) + int'(lat_sel);

  // R3
  prim_after_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (lead_p >= need_p) && (dp != '0));

  // R4
  bkup_after_prim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (db > dp) && (db < STAMP_W'(NUM_SLOTS)));

  // R5
  prim_was_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> !tbl_q[pidx] || (rel_valid && rel_idx == pidx));

  // R5
  bkup_was_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> !tbl_q[bidx] || (rel_valid && rel_idx == bidx));

  // R5
  booked_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |=> tbl_q[$past(pidx)] && tbl_q[$past(bidx)]);

  // R6
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !mem_valid_o && !gnt_valid_o);

  // R7
  issue_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> req_valid_i && req_ready_o && gnt_valid_o);
endmodule

bind slot_sched slot_sched_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .SLOT_CYC  (SLOT_CYC),
  .LAT_W     (LAT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_valid_o (mem_valid_o),
  .gnt_valid_o (gnt_valid_o),
  .gnt_prim_o  (gnt_prim_o),
  .gnt_bkup_o  (gnt_bkup_o),
  .slot_now_o  (slot_now_o),
  .phase_q     (phase_q),
  .lat_sel     (lat_sel),
  .tbl_q       (tbl_all),
  .rel_valid   (rel_en),
  .rel_idx     (rel_idx)
);

// File: tb/tb_slot_sched.sv
`timescale 1ns/1ps
module tb_slot_sched;
  localparam int NS = 64, SC = 4, AW = 32, TW = 4, NM = 4, LW = 9, DL = 40;
  localparam int SW = 7, MW = 2, NT = 16;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [MW-1:0] cfg_mod = '0;
  logic [LW-1:0] cfg_lat = '0;
  logic          req_valid = 1'b0, req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [MW-1:0] req_mod = '0;
  logic [TW-1:0] req_tag = '0;
  logic          mem_valid, gnt_valid;
  logic [AW-1:0] mem_addr;
  logic [MW-1:0] mem_mod;
  logic [TW-1:0] mem_tag, gnt_tag;
  logic [SW-1:0] gnt_prim, gnt_bkup, slot_now;
  logic          cpl_valid = 1'b0, cpl_use = 1'b0;
  logic [TW-1:0] cpl_tag = '0;

  always #2 clk = ~clk;

  slot_sched #(.NUM_SLOTS(NS), .SLOT_CYC(SC), .ADDR_W(AW), .TAG_W(TW),
               .NUM_MOD(NM), .LAT_W(LW), .DEF_LAT(DL)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_mod_i(cfg_mod), .cfg_lat_i(cfg_lat),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_mod_i(req_mod), .req_tag_i(req_tag),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_mod_o(mem_mod), .mem_tag_o(mem_tag),
    .gnt_valid_o(gnt_valid), .gnt_tag_o(gnt_tag), .gnt_prim_o(gnt_prim), .gnt_bkup_o(gnt_bkup),
    .cpl_valid_i(cpl_valid), .cpl_tag_i(cpl_tag), .cpl_use_i(cpl_use),
    .slot_now_o(slot_now)
  );

  int     checks = 0, errors = 0;
  longint cyc = 0;
  bit     done = 0;
  int     lat_m [NM];
  bit     tlive [NT];
  longint tbk   [NT];
  longint tage  [NT];
  bit     booked [longint];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint ceil_div(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  // one cycle: drive at negedge, check before posedge, update model after it
  task automatic step(input bit rv, input int md, input int tg,
                      input bit cv, input int ct, input bit cu,
                      input bit cw, input int cm, input int cl,
                      input string lbl, output bit granted);
    longint t, cur, start, p, b, act_abs;
    bit er;
    @(negedge clk);
    req_valid = rv; req_mod = MW'(md); req_tag = TW'(tg);
    req_addr  = $urandom();
    cpl_valid = cv; cpl_tag = TW'(ct); cpl_use = cu;
    cfg_we = cw; cfg_mod = MW'(cm); cfg_lat = LW'(cl);
    #1;
    t = cyc; cur = t / SC;
    // R8, R9: release applied before the search of this cycle
    if (cv && tlive[ct] && !cu && tbk[ct] > cur) booked.delete(tbk[ct]);
    start = ceil_div(t + lat_m[md], SC);
    if (start < cur + 1) start = cur + 1;
    p = -1; b = -1;
    for (longint s = start; s <= cur + NS - 1; s++)
      if (!booked.exists(s)) begin p = s; break; end
    if (p >= 0)
      for (longint s = p + 1; s <= cur + NS - 1; s++)
        if (!booked.exists(s)) begin b = s; break; end
    er = (p >= 0) && (b >= 0);
    if (rv) begin
      chk(req_ready == er, "R6", {lbl, " ready"}, req_ready, er);
      if (er) begin
        chk(mem_valid && gnt_valid, "R7", {lbl, " issue"}, mem_valid, 1);
        chk(mem_addr == req_addr && mem_mod == MW'(md) && mem_tag == TW'(tg) && gnt_tag == TW'(tg),
            "R7", {lbl, " fields"}, mem_tag, tg);
        chk(gnt_prim == SW'(p % 128), "R3", {lbl, " primary"}, gnt_prim, p % 128);
        chk(gnt_bkup == SW'(b % 128), "R4", {lbl, " backup"}, gnt_bkup, b % 128);
        act_abs = cur + longint'(SW'(gnt_prim - SW'(cur % 128)));
        chk(!booked.exists(act_abs), "R5", {lbl, " primary already booked"}, act_abs, p);
        chk(slot_now == SW'(cur % 128), "R10", {lbl, " slot counter"}, slot_now, cur % 128);
      end else begin
        chk(!mem_valid && !gnt_valid, "R6", {lbl, " stalled issue"}, mem_valid, 0);
      end
    end else begin
      chk(!mem_valid && !gnt_valid, "R7", {lbl, " idle issue"}, mem_valid, 0);
    end
    @(posedge clk);
    #1;
    if (cv) tlive[ct] = 0;
    if (rv && er) begin
      booked[p] = 1; booked[b] = 1;
      tlive[tg] = 1; tbk[tg] = b; tage[tg] = t;
    end
    if (cw) lat_m[cm] = cl;
    granted = rv && er;
  endtask

  task automatic idle(input int n);
    bit g;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle", g);
  endtask

  task automatic align();
    bit g;
    while (cyc % SC != 0) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "align", g);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit g;
    void'($urandom(32'd4242));
    for (int m = 0; m < NM; m++) lat_m[m] = DL;
    for (int k = 0; k < NT; k++) begin tlive[k] = 0; tbk[k] = 0; tage[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(slot_now == '0, "R1", "slot counter after reset", slot_now, 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(!gnt_valid && !mem_valid, "R1", "no grant after reset", gnt_valid, 0);

    // basic grants, default latency
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "base", g);
    step(1, 0, 1, 0, 0, 0, 0, 0, 0, "base", g);
    step(1, 0, 2, 0, 0, 0, 0, 0, 0, "base", g);
    // R2: write and request in the same cycle uses the old latency
    step(1, 1, 3, 0, 0, 0, 1, 1, 7, "R2 old", g);
    step(1, 1, 4, 0, 0, 0, 1, 2, 0, "R2 new", g);
    step(1, 2, 5, 0, 0, 0, 0, 0, 0, "R2 zero", g);
    step(1, 2, 6, 0, 0, 0, 0, 0, 0, "R2 zero", g);
    // R8: primary-used releases backup, backup-used releases nothing
    step(1, 1, 7, 1, 0, 0, 0, 0, 0, "R8 prim used", g);
    step(1, 1, 8, 1, 1, 1, 0, 0, 0, "R8 bkup used", g);
    for (int k = 2; k < 9; k++) step(1, 0, k + 7, 1, k, k & 1, 0, 0, 0, "R8", g);
    for (int k = 9; k < 16; k++) step(0, 0, 0, 1, k, 0, 0, 0, 0, "drain", g);

    idle(100);
    step(0, 0, 0, 0, 0, 0, 1, 3, 236, "cfg", g);
    step(0, 0, 0, 0, 0, 0, 1, 2, 300, "cfg", g);
    align();
    step(1, 3, 8, 0, 0, 0, 0, 0, 0, "win A", g);
    chk(g, "R3", "window first grant", g, 1);
    step(1, 3, 9, 0, 0, 0, 0, 0, 0, "win B", g);
    chk(g, "R4", "window second grant", g, 1);
    // R9: only the same-cycle release makes room
    step(1, 3, 10, 1, 8, 0, 0, 0, 0, "R9", g);
    chk(g, "R9", "grant through same-cycle release", g, 1);
    // R6: table full inside the window
    step(1, 3, 11, 0, 0, 0, 0, 0, 0, "R6 full", g);
    chk(!g && !req_ready, "R6", "full table stalls", g, 0);
    // R6: latency beyond the horizon
    step(1, 2, 11, 0, 0, 0, 0, 0, 0, "R6 horizon", g);
    chk(!g, "R6", "beyond horizon stalls", g, 0);
    for (int k = 9; k < 11; k++) step(0, 0, 0, 1, k, 1, 0, 0, 0, "drain", g);

    // R10: entries reused after a full horizon
    idle(300);
    align();
    step(1, 3, 12, 0, 0, 0, 0, 0, 0, "R10 reuse", g);
    chk(g, "R10", "entry reused after wrap", g, 1);
    step(1, 3, 13, 0, 0, 0, 0, 0, 0, "R10 reuse", g);
    step(0, 0, 0, 0, 0, 0, 1, 2, 90, "cfg", g);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      int  free_t [$];
      int  live_t [$];
      int  tg, ct, oldest;
      bit  rv, cv, cw;
      free_t.delete(); live_t.delete();
      oldest = -1;
      for (int k = 0; k < NT; k++) begin
        if (tlive[k]) begin
          live_t.push_back(k);
          if (cyc - tage[k] > 120) oldest = k;
        end else free_t.push_back(k);
      end
      rv = (free_t.size() > 0) && ($urandom_range(0, 9) < 6);
      tg = rv ? free_t[$urandom_range(0, free_t.size() - 1)] : 0;
      cv = 0; ct = 0;
      if (oldest >= 0) begin cv = 1; ct = oldest; end
      else if (live_t.size() > 0 && $urandom_range(0, 9) < 4) begin
        cv = 1; ct = live_t[$urandom_range(0, live_t.size() - 1)];
      end
      cw = ($urandom_range(0, 19) == 0);
      step(rv, $urandom_range(0, NM - 1), tg, cv, ct, $urandom_range(0, 1),
           cw, $urandom_range(0, NM - 1), $urandom_range(0, 220), "rand", g);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule